// File: doc/BRIEF.md
# GPIO Bank Interrupt Cause Unit

This block turns the polarity-corrected input levels of a 32-pin general-purpose I/O bank into interrupt requests. Every pin can raise a request in two ways. In level mode the pin's current input level is qualified by a per-pin level enable. In edge mode a low-to-high change of the pin's input is captured in a sticky cause bit, which is then qualified by a per-pin edge enable. Because the inputs have already been polarity-corrected, a pin set to inverted polarity catches falling edges of the raw line.

Each pin's request is the OR of its qualified level request and its qualified edge request. The pin requests are then ORed in groups of eight consecutive pins into four registered summary lines, which go to a central interrupt controller. Software uses a small register bus to program the two enable registers, to read them and the captured edges back, and to acknowledge captured edges one at a time. A write to the capture register clears every bit written as 0 and keeps every bit written as 1.

Top module: `gpio_irq_unit`

## Requirements
- R1: A pin's level request equals its input bit ANDed with its level-enable bit. Level-enable is register address 2, bit p for pin p.
- R2: A 0-to-1 change of an input bit between two consecutive cycles sets that pin's bit in the capture register (address 0). A 1-to-0 change sets nothing. A set bit stays set until software clears it.
- R3: A captured edge reaches a summary line only while the pin's edge-enable bit is 1. Edge-enable is address 1, bit p.
- R4: A write to address 0 clears each capture bit whose write-data bit is 0 and leaves unchanged each bit whose write-data bit is 1.
- R5: A pin's request is its level request ORed with its qualified edge request. Summary line g is the OR of the requests of pins 8g to 8g+7.
- R6: If an edge of a pin arrives in the same cycle as a write that clears that pin's capture bit, the bit ends up set.
- R7: Reset clears both enable registers, the capture register and the summary lines. An input that is already high in the first cycle after reset does not set a capture bit.
- R8: Addresses 0, 1 and 2 read back the capture, edge-enable and level-enable registers. Address 3 reads as zero, and a write to address 3 changes no register.
- R9: The summary lines are registered. A change of an input level or of a register becomes visible on the summary lines one clock edge after the edge at which that change takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 32 | Polarity-corrected input level of each pin |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 capture, 1 edge-enable, 2 level-enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_grp | output | 4 | Registered summary requests, one per group of eight pins |

## Verification
The hardest case to create is an edge that arrives in exactly the same cycle as a software write clearing that pin's capture bit. The bench brings this about by driving the pin's rising input and the clearing write at the same falling clock edge, so that both land on one rising edge. It then reads the capture register. The bench also holds all inputs high through reset so that the first post-reset cycle cannot register as an edge. Every pin is walked through set, hold on a falling input, keep-on-one and clear-on-zero, under two complementary edge-enable patterns.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CAUSE = 2'd0,
        SEL_EMASK = 2'd1,
        SEL_LMASK = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl,
    output logic [NUM_PINS-1:0] rise
);
    typedef struct packed {
        logic                armed;
        logic [NUM_PINS-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = 1'b1;
        st_d.prev  = pin_lvl;
        rise       = st_q.armed ? (pin_lvl & ~st_q.prev) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // No rise is reported in the first cycle after reset
    AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> $past(rise) == '0); // R7
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    input  logic [NUM_PINS-1:0] rise,
    output logic [NUM_PINS-1:0] cause,
    output logic [NUM_PINS-1:0] emask,
    output logic [NUM_PINS-1:0] lmask,
    output logic [NUM_PINS-1:0] rdata
);
    typedef struct packed {
        logic [NUM_PINS-1:0] cause;
        logic [NUM_PINS-1:0] emask;
        logic [NUM_PINS-1:0] lmask;
    } reg_st_t;

    reg_st_t  st_d, st_q;
    reg_sel_e sel;
    logic     cause_wr;

    always_comb begin
        sel      = reg_sel_e'(addr);
        cause_wr = we && (sel == SEL_CAUSE);
        st_d     = st_q;
        if (we) begin
            case (sel)
                SEL_CAUSE: st_d.cause = st_q.cause & wdata;
                SEL_EMASK: st_d.emask = wdata;
                SEL_LMASK: st_d.lmask = wdata;
                default:   st_d = st_q;
            endcase
        end
        // fresh edges override an acknowledge in the same cycle
        st_d.cause = st_d.cause | rise;

        case (sel)
            SEL_CAUSE: rdata = st_q.cause;
            SEL_EMASK: rdata = st_q.emask;
            SEL_LMASK: rdata = st_q.lmask;
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause = st_q.cause;
    assign emask = st_q.emask;
    assign lmask = st_q.lmask;

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |=> ((st_q.cause & $past(st_q.cause)) == $past(st_q.cause))); // R2
    AST_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> ((~st_q.cause & $past(st_q.cause) & $past(wdata)) == '0)); // R4
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((st_q.cause & $past(rise)) == $past(rise))); // R6
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int NUM_PINS   = 32,
    parameter int GROUP_PINS = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PINS-1:0]               pin_lvl,
    input  logic [NUM_PINS-1:0]               lmask,
    input  logic [NUM_PINS-1:0]               cause,
    input  logic [NUM_PINS-1:0]               emask,
    output logic [NUM_PINS/GROUP_PINS-1:0]    irq
);
    localparam int NUM_GROUPS = NUM_PINS / GROUP_PINS;

    typedef struct packed {
        logic [NUM_GROUPS-1:0] irq;
    } merge_st_t;

    merge_st_t           st_d, st_q;
    logic [NUM_PINS-1:0] pin_req;
    logic [NUM_GROUPS-1:0] grp_req;

    always_comb begin
        pin_req = (pin_lvl & lmask) | (cause & emask);
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_req[g] = |pin_req[g*GROUP_PINS +: GROUP_PINS];
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = grp_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

    AST_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lmask == '0 && emask == '0) |=> (st_q.irq == '0)); // R3
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int GROUP_PINS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            pin_lvl,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [NUM_PINS-1:0]            bus_wdata,
    output logic [NUM_PINS-1:0]            bus_rdata,
    output logic [NUM_PINS/GROUP_PINS-1:0] irq_grp
);
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] cause;
    logic [NUM_PINS-1:0] emask;
    logic [NUM_PINS-1:0] lmask;

    gpio_irq_edge #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (pin_lvl),
        .rise    (rise)
    );

    gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rise  (rise),
        .cause (cause),
        .emask (emask),
        .lmask (lmask),
        .rdata (bus_rdata)
    );

    gpio_irq_merge #(.NUM_PINS(NUM_PINS), .GROUP_PINS(GROUP_PINS)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_lvl (pin_lvl),
        .lmask   (lmask),
        .cause   (cause),
        .emask   (emask),
        .irq     (irq_grp)
    );

    AST_ADDR3_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3) |=> ($stable(emask) && $stable(lmask))); // R8
endmodule

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_grp;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_grp(irq_grp)
    );

    function automatic logic [3:0] grp_or(input logic [31:0] v);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = |v[g*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, m, lm;
        // R7: inputs held high across reset must not look like an edge
        pin_lvl = '1;
        cyc(4);
        rst_n = 1'b1;
        cyc(3);
        rd(2'd0, d); chk("R7 capture after reset", d, 32'h0);
        rd(2'd1, d); chk("R7 edge-enable after reset", d, 32'h0);
        rd(2'd2, d); chk("R7 level-enable after reset", d, 32'h0);
        chk("R7 irq after reset", {28'h0, irq_grp}, 32'h0);
        pin_lvl = '0;
        cyc(2);

        // R8: readback and inert address 3
        wr(2'd1, 32'hA5C3_0F96); wr(2'd2, 32'h1234_8765);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R8 edge-enable readback", d, 32'hA5C3_0F96);
        rd(2'd2, d); chk("R8 level-enable readback", d, 32'h1234_8765);
        rd(2'd3, d); chk("R8 address 3 reads zero", d, 32'h0);
        wr(2'd1, 32'h0); wr(2'd2, 32'h0); wr(2'd0, 32'h0);

        // R1/R9: level sweep, walking one and walking zero with pseudo-random enables
        for (int p = 0; p < 32; p++) begin
            lm = 32'h1 << p;
            wr(2'd2, lm);
            pin_lvl = lm;
            @(negedge clk);
            chk("R9 level one edge later", {28'h0, irq_grp}, {28'h0, grp_or(lm)});
            pin_lvl = ~lm;
            cyc(1);
            chk("R1 other pins masked", {28'h0, irq_grp}, 32'h0);
            m = 32'h9E37_79B9 * (p + 1);
            lm = m ^ (m >> 7);
            wr(2'd2, lm);
            pin_lvl = m;
            cyc(1);
            chk("R1 level pattern", {28'h0, irq_grp}, {28'h0, grp_or(m & lm)});
        end
        wr(2'd2, 32'h0);
        pin_lvl = '0;
        cyc(2);
        wr(2'd0, 32'h0);

        // R2/R3/R4/R5: edge capture walk under two complementary enables
        for (int k = 0; k < 2; k++) begin
            m = (k == 0) ? 32'h3C5A_0FF1 : ~32'h3C5A_0FF1;
            wr(2'd1, m);
            for (int p = 0; p < 32; p++) begin
                pin_lvl = 32'h1 << p;
                cyc(2);
                rd(2'd0, d); chk("R2 rise sets capture", d, 32'h1 << p);
                chk("R3 enable gates edge", {28'h0, irq_grp},
                    m[p] ? {28'h0, grp_or(32'h1 << p)} : 32'h0);
                pin_lvl = '0;
                cyc(2);
                rd(2'd0, d); chk("R2 fall keeps, sets nothing", d, 32'h1 << p);
                wr(2'd0, 32'hFFFF_FFFF);
                rd(2'd0, d); chk("R4 ones keep", d, 32'h1 << p);
                wr(2'd0, ~(32'h1 << p));
                rd(2'd0, d); chk("R4 zero clears", d, 32'h0);
            end
        end

        // R4: selective acknowledge of many bits
        pin_lvl = '1;
        cyc(2);
        pin_lvl = '0;
        wr(2'd0, 32'hF0F0_1234);
        rd(2'd0, d); chk("R4 selective clear", d, 32'hF0F0_1234);
        wr(2'd0, 32'h0);

        // R5: level and edge of different pins OR into one group line
        wr(2'd1, 32'h0000_1000);
        wr(2'd2, 32'h0000_0200);
        pin_lvl = 32'h0000_1000;
        cyc(2);
        pin_lvl = 32'h0000_0200;
        cyc(2);
        chk("R5 level+edge group1", {28'h0, irq_grp}, 32'h2);
        pin_lvl = 32'h0;
        cyc(2);
        chk("R5 edge alone group1", {28'h0, irq_grp}, 32'h2);
        wr(2'd0, 32'h0);
        cyc(1);
        chk("R5 all cleared", {28'h0, irq_grp}, 32'h0);
        wr(2'd1, 32'h0); wr(2'd2, 32'h0);

        // R6: rising input and clearing write meet at one clock edge
        @(negedge clk);
        pin_lvl = 32'h0000_0020;
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h0;
        @(negedge clk);
        bus_we = 1'b0;
        rd(2'd0, d); chk("R6 edge beats clear (bit was 0)", d, 32'h0000_0020);
        pin_lvl = '0;
        cyc(1);
        @(negedge clk);
        pin_lvl = 32'h0000_0020;
        bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h0;
        @(negedge clk);
        bus_we = 1'b0;
        rd(2'd0, d); chk("R6 edge beats clear (bit was 1)", d, 32'h0000_0020);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule